// File: doc/BRIEF.md
# Polled Serial Bit Sampler

This block recovers asynchronous serial characters from a parallel port value that the host samples on every CPU clock. It registers the port word once, reduces three masked bits to a single line level, and watches that level for a high-to-low transition. It then times its samples with fixed CPU-cycle counts, the way a software polling loop would. The first data sample lands one and a half bit periods after the start edge, and each later sample follows one bit period after the previous one.

After eight data bits, received least significant first, the block samples one stop bit. A high stop bit delivers the byte with a single-cycle valid pulse. A low stop bit raises a single-cycle framing-error pulse and discards the byte. The block then ignores the line until it has gone high again. An enable input gates start detection and cancels any character in progress.

Top module: `polled_serial_rx`

## Requirements
- R1: The line level is high exactly when the registered port value ANDed with 0x16 (port bits 1, 2 and 4) is nonzero; all other port bits have no effect on reception.
- R2: While enabled and idle, a character begins when the registered line level goes from high to low.
- R3: If the port first shows the start level at clock edge n, data bit i (i = 0..7) is taken from the port value present at edge n+62+47*i. The stop bit is taken from the value present at edge n+438, and the result outputs change after edge n+439.
- R4: Data bits arrive least significant first and are sampled 47 cycles apart; the received byte equals the transmitted byte for every value 0x00..0xFF.
- R5: A high stop bit produces `rx_valid_o` high for exactly one cycle, with `rx_data_o` holding the byte, and no framing error.
- R6: A low stop bit produces `frame_err_o` high for exactly one cycle and no valid pulse. No new character starts until the line has returned high.
- R7: High-to-low transitions of the line while a character is in progress do not restart or shift the sampling schedule.
- R8: While `en_i` is low, no character starts and no valid or error pulse appears. Dropping `en_i` during a character cancels it without output.
- R9: After reset `rx_valid_o` and `frame_err_o` are low and `rx_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Enables start detection; low cancels a character |
| port_i | input | 8 | Raw port value sampled each cycle |
| rx_data_o | output | 8 | Last byte received with a good stop bit |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_data_o` is updated |
| frame_err_o | output | 1 | One-cycle pulse when the stop bit reads low |

## Verification
The bench builds the block with its default schedule of 62 and 47 cycles, eight data bits and the 0x16 line mask, so real character timing is exercised. With those values, a full sweep of all 256 byte values fits in the run. That sweep checks each byte's content and the exact cycle of its valid pulse, and it mixes which masked bit carries the high level and whether the unmasked bits are set. Targeted frames cover a low stop bit held past the sample point, a disabled receiver, and a character cut short by dropping the enable.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } rx_state_e;

  // Line level: any masked port bit set reads as a high line.
  function automatic logic line_level(input logic [15:0] port, input logic [15:0] mask);
    return |(port & mask);
  endfunction

  // Reload value for a countdown that expires after 'cycles' edges.
  function automatic int unsigned reload_of(input int unsigned cycles);
    return cycles - 1;
  endfunction

endpackage

// File: rtl/psr_front.sv
module psr_front #(
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] MASK = 8'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_i,
  output logic              line_o,
  output logic              fall_o
);
  import psr_pkg::*;

  logic [PORT_W-1:0] port_q;
  logic              line_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q <= MASK;
      line_d <= 1'b1;
    end else begin
      port_q <= port_i;
      line_d <= line_o;
    end
  end

  assign line_o = line_level(16'(port_q), 16'(MASK));
  assign fall_o = line_d && !line_o;

endmodule

// File: rtl/psr_timer.sv
module psr_timer #(
  parameter int unsigned FIRST_DELAY = 62,
  parameter int unsigned BIT_DELAY   = 47
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic load_first_i,
  input  logic load_bit_i,
  output logic expire_o
);
  import psr_pkg::*;

  localparam int unsigned MAXD = (FIRST_DELAY > BIT_DELAY) ? FIRST_DELAY : BIT_DELAY;
  localparam int unsigned CW   = $clog2(MAXD) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_first_i) begin
      cnt_q <= CW'(reload_of(FIRST_DELAY));
    end else if (load_bit_i) begin
      cnt_q <= CW'(reload_of(BIT_DELAY));
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = active_i && (cnt_q == '0);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < MAXD); // R3

endmodule

// File: rtl/psr_shift.sv
module psr_shift #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 shift_i,
  input  logic                 bit_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 full_o
);
  localparam int unsigned NW = $clog2(DATA_BITS + 1);

  logic [DATA_BITS-1:0] sr_q;
  logic [NW-1:0]        n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
      n_q  <= '0;
    end else if (clear_i) begin
      n_q <= '0;
    end else if (shift_i) begin
      sr_q <= {bit_i, sr_q[DATA_BITS-1:1]};
      n_q  <= n_q + 1'b1;
    end
  end

  assign data_o = sr_q;
  assign full_o = (32'(n_q) == DATA_BITS);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(n_q) <= DATA_BITS); // R4

endmodule

// File: rtl/polled_serial_rx.sv
module polled_serial_rx #(
  parameter int unsigned PORT_W      = 8,
  parameter logic [PORT_W-1:0] LINE_MASK = 8'h16,
  parameter int unsigned FIRST_DELAY = 62,
  parameter int unsigned BIT_DELAY   = 47,
  parameter int unsigned DATA_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [PORT_W-1:0]    port_i,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o,
  output logic                 frame_err_o
);
  import psr_pkg::*;

  rx_state_e            state_q;
  logic                 line, fall, expire, full;
  logic                 start_evt, data_evt, stop_evt;
  logic [DATA_BITS-1:0] shreg;

  psr_front #(.PORT_W(PORT_W), .MASK(LINE_MASK)) u_front (
    .clk(clk), .rst_n(rst_n), .port_i(port_i), .line_o(line), .fall_o(fall)
  );

  assign start_evt = (state_q == ST_IDLE) && en_i && fall;
  assign data_evt  = (state_q == ST_RUN) && en_i && expire && !full;
  assign stop_evt  = (state_q == ST_RUN) && en_i && expire && full;

  psr_timer #(.FIRST_DELAY(FIRST_DELAY), .BIT_DELAY(BIT_DELAY)) u_timer (
    .clk(clk), .rst_n(rst_n), .active_i(state_q == ST_RUN),
    .load_first_i(start_evt), .load_bit_i(data_evt), .expire_o(expire)
  );

  psr_shift #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear_i(start_evt), .shift_i(data_evt),
    .bit_i(line), .data_o(shreg), .full_o(full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rx_data_o   <= '0;
      rx_valid_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      rx_valid_o  <= 1'b0;
      frame_err_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_evt) state_q <= ST_RUN;
        ST_RUN: begin
          if (!en_i) begin
            state_q <= ST_IDLE;
          end else if (stop_evt) begin
            if (line) begin
              rx_data_o  <= shreg;
              rx_valid_o <= 1'b1;
              state_q    <= ST_IDLE;
            end else begin
              frame_err_o <= 1'b1;
              state_q     <= ST_HOLD;
            end
          end
        end
        ST_HOLD: if (!en_i || line) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o); // R5
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid_o && frame_err_o)); // R6
  AST_HOLD_WAITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !line) |=> state_q != ST_RUN); // R6
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && en_i && fall) |=> state_q == ST_RUN); // R2
  AST_RUN_KEEPS_SCHEDULE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && en_i && !expire) |=> state_q == ST_RUN); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!rx_valid_o && !frame_err_o)); // R8

endmodule

// File: tb/polled_serial_rx_bench.sv
module polled_serial_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [7:0] port = 8'h16;
  logic [7:0] data;
  logic       valid, ferr;
  int         checks = 0, failures = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  polled_serial_rx u_polled_serial_rx (
    .clk(clk), .rst_n(rst_n), .en_i(en), .port_i(port),
    .rx_data_o(data), .rx_valid_o(valid), .frame_err_o(ferr)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one character; start level is applied before edge k=1.
  // Good stop: valid after edge 440 (detect edge 2, +62, +47*8).
  task automatic frame(input logic [7:0] b, input logic good, input logic [7:0] hv,
                       input logic [7:0] lv, input logic en_lvl, input int drop_at,
                       input logic expect_out, input int len, input string req);
    int vcnt = 0, fcnt = 0, vk = 0, j;
    logic [7:0] got = 8'h00;
    @(negedge clk);
    en = en_lvl;
    port = lv;
    for (int k = 1; k <= len; k++) begin
      @(posedge clk); #1;
      if (valid) begin vcnt++; vk = k; got = data; end
      if (ferr) begin fcnt++; vk = k; end
      j = k / 47;
      if (j == 0) port = lv;
      else if (j <= 8) port = b[j-1] ? hv : lv;
      else if (j <= 11) port = good ? hv : lv;
      else port = hv;
      en = (k == drop_at) ? 1'b0 : en_lvl;
    end
    en = 1'b1;
    if (!expect_out) begin
      chk(vcnt == 0 && fcnt == 0, req, vcnt + fcnt, 0);
    end else if (good) begin
      chk(vcnt == 1 && fcnt == 0, req, vcnt, 1);
      chk(vk == 440, {req, " R3 latency"}, vk, 440);
      chk(got == b, {req, " R4 data"}, got, b);
    end else begin
      chk(fcnt == 1 && vcnt == 0, {req, " R6 ferr"}, fcnt, 1);
      chk(vk == 440, {req, " R6 timing"}, vk, 440);
    end
  endtask

  initial begin
    logic [7:0] hvs [5] = '{8'h02, 8'h04, 8'h10, 8'h16, 8'hFF};
    repeat (3) @(posedge clk);
    #1;
    chk(!valid && !ferr && data == 8'h00, "R9 reset", data, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);
    // R1 masking: high via single masked bits, low with unmasked bits set
    frame(8'hA5, 1'b1, 8'h02, 8'hE9, 1'b1, 0, 1'b1, 480, "R1 bit1");
    frame(8'h3C, 1'b1, 8'h10, 8'hE9, 1'b1, 0, 1'b1, 480, "R1 bit4");
    // R7 many falls mid-character
    frame(8'h55, 1'b1, 8'h04, 8'h00, 1'b1, 0, 1'b1, 480, "R7 alt55");
    frame(8'hAA, 1'b1, 8'h04, 8'h00, 1'b1, 0, 1'b1, 480, "R7 altAA");
    // R5/R2 back-to-back after a good frame
    frame(8'h00, 1'b1, 8'h16, 8'h00, 1'b1, 0, 1'b1, 480, "R5 R2 zero");
    // R6 low stop bit held long, then recovery
    frame(8'h81, 1'b0, 8'h16, 8'h00, 1'b1, 0, 1'b1, 600, "R6 badstop");
    frame(8'h7E, 1'b1, 8'h16, 8'h00, 1'b1, 0, 1'b1, 480, "R6 recover");
    // R8 disabled whole frame, then abort mid-frame
    frame(8'h00, 1'b1, 8'h16, 8'h00, 1'b0, 0, 1'b0, 480, "R8 disabled");
    frame(8'hFF, 1'b1, 8'h16, 8'h00, 1'b1, 200, 1'b0, 480, "R8 abort");
    frame(8'hC3, 1'b1, 8'h16, 8'h00, 1'b1, 0, 1'b1, 480, "R8 after");
    // R4 sweep of every byte value
    for (int b = 0; b < 256; b++) begin
      frame(8'(b), 1'b1, hvs[b % 5], b[0] ? 8'hE9 : 8'h00, 1'b1, 0, 1'b1, 480, "R4 sweep");
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule